// File: doc/BRIEF.md
# Two-Way Address Translation Cache

This block caches recently used page translations so a load/store unit or instruction fetcher can turn a virtual address into a physical address without walking the page table. It keeps two independent arrays: one serves instruction fetches and one serves every other access kind. Each set of an array holds two ways. Every way stores a page tag and the second word of the page-table entry. The physical page number is read from the upper bits of that word. One recency bit per set steers replacement.

A client presents an address and an access kind on a valid/ready lookup channel. The registered response arrives one cycle after acceptance and reports miss, hit, or a hit that needs an update. In the last case a store hit a page whose changed bit was clear, so the in-memory entry must also be marked. The lookup channel is back-pressured by the response channel. A lookup is accepted only when the response register is empty or is being drained in the same cycle, and a held response stays unchanged until it is taken. After a miss, the external table walker installs the entry through a plain fill port. A plain invalidate port drops a page in both arrays.

Top module: `tcache`

## Requirements
- R1: After reset every way of every set in both arrays is invalid (tag all ones), `rs_valid` is low and `lk_ready` is high. A lookup of any address, including one whose tag is all ones, misses.
- R2: Lookups and fills of kind fetch (3) use the instruction array. Kinds probe (0), read (1) and write (2) use the data array. An entry filled in one array is never found in the other.
- R3: The tag is the address shifted right by the page shift (12), and the set index is the low 4 tag bits (address bits 15:12). On a hit, `rs_paddr` equals the entry's bits 31:12 concatenated with address bits 11:0. On a miss it is zero. Status codes are: miss 0, hit 1, update-needed 2.
- R4: A write lookup that hits an entry whose changed bit (bit 7 of the cached entry word) is 0 returns status 2 and sets that cached bit. It leaves the recency bit alone. A later write to the same page returns status 1.
- R5: A read, write or fetch hit sets the set's recency bit to the way that hit. A probe hit leaves it unchanged.
- R6: A fill goes to way 1 when the recency bit is 0 and way 0 holds a valid tag, and to way 0 otherwise. The recency bit then names the filled way.
- R7: A fill of kind probe is ignored.
- R8: Invalidate clears both ways of the indexed set in both arrays. Other sets are untouched.
- R9: When a fill and an accepted lookup address the same set of the same array in one cycle, the lookup answers from the contents before the fill, and only the fill's state change is kept.
- R10: `lk_ready` equals `!rs_valid || rs_ready`. While `rs_valid` is high and `rs_ready` is low, the response holds unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle when high with lk_valid |
| lk_addr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 probe, 1 read, 2 write, 3 fetch |
| rs_valid | output | 1 | Response valid |
| rs_ready | input | 1 | Response taken |
| rs_status | output | 2 | 0 miss, 1 hit, 2 hit needing changed-bit update |
| rs_paddr | output | 32 | Translated physical address (zero on miss) |
| rs_pte | output | 32 | Cached entry word after any changed-bit update (zero on miss) |
| fl_valid | input | 1 | Fill strobe from the table walker |
| fl_addr | input | 32 | Virtual address of the page being filled |
| fl_kind | input | 2 | Kind of the access that missed (selects array; probe ignored) |
| fl_pte | input | 32 | Entry word to cache |
| inv_valid | input | 1 | Invalidate strobe |
| inv_addr | input | 32 | Virtual address whose set is cleared |

## Verification
A fill and an accepted lookup can land on the same set of the same array in one cycle. The bench drives both on one clock edge against a set whose two ways are already full. It looks up the way-1 page, which would set the recency bit to 1, while the fill installs a third page and sets the bit to 0. The response must be a hit from the old contents. A follow-up fill must then evict the way-1 page, which shows that the fill's recency value survived. Back-pressure is a second overlap: a new request stalls behind a held response, and the bench checks that the response stays frozen until it is drained.

// File: rtl/tcache_pkg.sv
package tcache_pkg;
  typedef enum logic [1:0] {
    K_PROBE = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2,
    K_FETCH = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_MISS = 2'd0,
    ST_HIT  = 2'd1,
    ST_SETC = 2'd2
  } lk_status_e;

  // position of the changed bit inside the cached entry word
  localparam int CHG_BIT = 7;
endpackage

// File: rtl/tcache_way_cmp.sv
module tcache_way_cmp #(
  parameter int TAG_W = 20
) (
  input  logic [TAG_W-1:0] stored,
  input  logic [TAG_W-1:0] req,
  output logic             match
);
  // the all-ones pattern marks an empty way and never matches
  assign match = (stored == req) && (stored != {TAG_W{1'b1}});
endmodule

// File: rtl/tcache_bank.sv
module tcache_bank
  import tcache_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int TAG_W = 20,
  parameter int PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_en,
  input  logic [1:0]       lk_kind,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             fl_en,
  input  logic [TAG_W-1:0] fl_tag,
  input  logic [PTE_W-1:0] fl_pte,
  input  logic             inv_en,
  input  logic [TAG_W-1:0] inv_tag,
  output logic [1:0]       lk_status,
  output logic [PTE_W-1:0] lk_pte
);
  localparam int SETS = 1 << SET_W;
  localparam int WAYS = 2;
  localparam logic [TAG_W-1:0] EMPTY = {TAG_W{1'b1}};

  logic [TAG_W-1:0] tag_q [WAYS][SETS];
  logic [PTE_W-1:0] pte_q [WAYS][SETS];
  logic [SETS-1:0]  recent_q;

  logic [SET_W-1:0] lk_set, fl_set, inv_set;
  assign lk_set  = lk_tag[SET_W-1:0];
  assign fl_set  = fl_tag[SET_W-1:0];
  assign inv_set = inv_tag[SET_W-1:0];

  logic [WAYS-1:0] way_hit;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    tcache_way_cmp #(.TAG_W(TAG_W)) u_cmp (
      .stored(tag_q[w][lk_set]),
      .req   (lk_tag),
      .match (way_hit[w])
    );
  end

  logic             any_hit, hit_way, needc, victim, fl_blk, lk_blk;
  logic [PTE_W-1:0] sel_pte;

  always_comb begin
    any_hit = |way_hit;
    hit_way = !way_hit[0];
    sel_pte = pte_q[hit_way][lk_set];
    needc   = any_hit && (acc_kind_e'(lk_kind) == K_WRITE) && !sel_pte[CHG_BIT];
    if (!any_hit) begin
      lk_status = ST_MISS;
      lk_pte    = '0;
    end else if (needc) begin
      lk_status = ST_SETC;
      lk_pte    = sel_pte | (PTE_W'(1) << CHG_BIT);
    end else begin
      lk_status = ST_HIT;
      lk_pte    = sel_pte;
    end
    victim = !recent_q[fl_set] && (tag_q[0][fl_set] != EMPTY);
    fl_blk = inv_en && (inv_set == fl_set);
    lk_blk = (fl_en && (fl_set == lk_set)) || (inv_en && (inv_set == lk_set));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++) begin
          tag_q[w][s] <= EMPTY;
          pte_q[w][s] <= '0;
        end
      recent_q <= '0;
    end else begin
      // lowest priority: state change caused by a lookup
      if (lk_en && any_hit && !lk_blk) begin
        if (needc)
          pte_q[hit_way][lk_set][CHG_BIT] <= 1'b1;
        else if (acc_kind_e'(lk_kind) != K_PROBE)
          recent_q[lk_set] <= hit_way;
      end
      if (fl_en && !fl_blk) begin
        tag_q[victim][fl_set] <= fl_tag;
        pte_q[victim][fl_set] <= fl_pte;
        recent_q[fl_set]      <= victim;
      end
      if (inv_en) begin
        tag_q[0][inv_set] <= EMPTY;
        tag_q[1][inv_set] <= EMPTY;
      end
    end
  end

  // R8
  inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> (tag_q[0][$past(inv_set)] == EMPTY) && (tag_q[1][$past(inv_set)] == EMPTY));

  // R6
  fill_recent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_en && !fl_blk) |=> (recent_q[$past(fl_set)] == $past(victim))
                           && (tag_q[$past(victim)][$past(fl_set)] == $past(fl_tag)));
endmodule

// File: rtl/tcache.sv
module tcache
  import tcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int SET_W      = 4,
  parameter int PTE_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [1:0]        lk_kind,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic [1:0]        rs_status,
  output logic [PTE_W-1:0]  rs_paddr,
  output logic [PTE_W-1:0]  rs_pte,
  input  logic              fl_valid,
  input  logic [ADDR_W-1:0] fl_addr,
  input  logic [1:0]        fl_kind,
  input  logic [PTE_W-1:0]  fl_pte,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr
);
  localparam int TAG_W = ADDR_W - PAGE_SHIFT;
  localparam int NBANK = 2; // 0: data, 1: instruction

  logic lk_fire;
  assign lk_ready = !rs_valid || rs_ready;
  assign lk_fire  = lk_valid && lk_ready;

  logic [1:0]       bank_status [NBANK];
  logic [PTE_W-1:0] bank_pte    [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic lk_en_b, fl_en_b;
    assign lk_en_b = lk_fire && ((lk_kind == K_FETCH) == (b == 1));
    assign fl_en_b = fl_valid && (fl_kind != K_PROBE) && ((fl_kind == K_FETCH) == (b == 1));
    tcache_bank #(.SET_W(SET_W), .TAG_W(TAG_W), .PTE_W(PTE_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_en    (lk_en_b),
      .lk_kind  (lk_kind),
      .lk_tag   (lk_addr[ADDR_W-1:PAGE_SHIFT]),
      .fl_en    (fl_en_b),
      .fl_tag   (fl_addr[ADDR_W-1:PAGE_SHIFT]),
      .fl_pte   (fl_pte),
      .inv_en   (inv_valid),
      .inv_tag  (inv_addr[ADDR_W-1:PAGE_SHIFT]),
      .lk_status(bank_status[b]),
      .lk_pte   (bank_pte[b])
    );
  end

  logic             sel_b;
  logic [1:0]       nxt_status;
  logic [PTE_W-1:0] nxt_pte, nxt_paddr;

  always_comb begin
    sel_b      = (lk_kind == K_FETCH);
    nxt_status = bank_status[sel_b];
    nxt_pte    = bank_pte[sel_b];
    nxt_paddr  = (nxt_status == ST_MISS) ? '0
               : {nxt_pte[PTE_W-1:PAGE_SHIFT], lk_addr[PAGE_SHIFT-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid  <= 1'b0;
      rs_status <= ST_MISS;
      rs_paddr  <= '0;
      rs_pte    <= '0;
    end else if (lk_fire) begin
      rs_valid  <= 1'b1;
      rs_status <= nxt_status;
      rs_paddr  <= nxt_paddr;
      rs_pte    <= nxt_pte;
    end else if (rs_ready) begin
      rs_valid  <= 1'b0;
    end
  end

  // R10
  hold_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> rs_valid && $stable(rs_status) && $stable(rs_paddr));

  // R4
  needc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> (rs_status != ST_SETC) || ($past(lk_kind) == K_WRITE));

  // R3
  offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> (rs_status == ST_MISS) || (rs_paddr[PAGE_SHIFT-1:0] == $past(lk_addr[PAGE_SHIFT-1:0])));

  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fire && (nxt_status == ST_MISS)) |=> (rs_paddr == '0));
endmodule

// File: tb/tb_tcache.sv
module tb_tcache;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        lk_valid = 0, rs_ready = 1, fl_valid = 0, inv_valid = 0;
  logic [31:0] lk_addr = 0, fl_addr = 0, fl_pte = 0, inv_addr = 0;
  logic [1:0]  lk_kind = 0, fl_kind = 0;
  logic        lk_ready, rs_valid;
  logic [1:0]  rs_status;
  logic [31:0] rs_paddr, rs_pte;
  int n_chk = 0, n_bad = 0;

  localparam logic [1:0] PR = 0, RD = 1, WR = 2, FE = 3;
  localparam logic [1:0] MISS = 0, HIT = 1, SETC = 2;

  always #4 clk = ~clk;

  tcache dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(logic [31:0] a, logic [1:0] k, output logic [1:0] st, output logic [31:0] pa);
    @(negedge clk); lk_addr = a; lk_kind = k; lk_valid = 1;
    @(posedge clk); @(negedge clk); lk_valid = 0;
    st = rs_status; pa = rs_paddr;
  endtask

  task automatic expect_look(string req, logic [31:0] a, logic [1:0] k, logic [1:0] est, logic [31:0] epa);
    logic [1:0] st; logic [31:0] pa;
    look(a, k, st, pa);
    chk({req, " status"}, st, est);
    chk({req, " paddr"}, pa, epa);
  endtask

  task automatic fill(logic [31:0] a, logic [1:0] k, logic [31:0] p);
    @(negedge clk); fl_addr = a; fl_kind = k; fl_pte = p; fl_valid = 1;
    @(posedge clk); @(negedge clk); fl_valid = 0;
  endtask

  task automatic inval(logic [31:0] a);
    @(negedge clk); inv_addr = a; inv_valid = 1;
    @(posedge clk); @(negedge clk); inv_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 rs_valid", rs_valid, 0);
    chk("R10 lk_ready idle", lk_ready, 1);
    expect_look("R1 empty", 32'h0000_3123, RD, MISS, 0);
    expect_look("R1 ones tag", 32'hFFFF_F123, RD, MISS, 0);
  endtask

  task automatic t_basic;
    fill(32'h0000_3000, RD, 32'h1234_5000);
    expect_look("R3 hit", 32'h0000_3456, RD, HIT, 32'h1234_5456);
    expect_look("R2 other array", 32'h0000_3456, FE, MISS, 0);
    fill(32'h0000_3000, FE, 32'hAAAA_A080);
    expect_look("R2 instr hit", 32'h0000_3010, FE, HIT, 32'hAAAA_A010);
    expect_look("R4 clean write", 32'h0000_3010, WR, SETC, 32'h1234_5010);
    chk("R4 pte bit", rs_pte, 32'h1234_5080);
    expect_look("R4 dirty write", 32'h0000_3020, WR, HIT, 32'h1234_5020);
  endtask

  task automatic t_replace;
    fill(32'h0000_5000, RD, 32'h1111_1080);
    fill(32'h0001_5000, RD, 32'h2222_2080);
    fill(32'h0002_5000, RD, 32'h3333_3080);
    expect_look("R6 evicted", 32'h0000_5000, RD, MISS, 0);
    expect_look("R6 way1", 32'h0001_5004, RD, HIT, 32'h2222_2004);
    expect_look("R5 way0", 32'h0002_5008, RD, HIT, 32'h3333_3008);
    fill(32'h0003_5000, RD, 32'h4444_4080);
    expect_look("R5 lru evicted", 32'h0001_5000, RD, MISS, 0);
    expect_look("R5 mru kept", 32'h0002_500C, RD, HIT, 32'h3333_300C);
    expect_look("R6 new", 32'h0003_5001, RD, HIT, 32'h4444_4001);
  endtask

  task automatic t_probe;
    fill(32'h0000_6000, RD, 32'h5555_5080);
    fill(32'h0001_6000, RD, 32'h6666_6080);
    expect_look("R5 touch way0", 32'h0000_6000, RD, HIT, 32'h5555_5000);
    expect_look("R5 probe hit", 32'h0001_6000, PR, HIT, 32'h6666_6000);
    fill(32'h0002_6000, RD, 32'h7777_7080);
    expect_look("R5 probe no recency", 32'h0001_6000, RD, MISS, 0);
    expect_look("R5 way0 kept", 32'h0000_6000, RD, HIT, 32'h5555_5000);
    fill(32'h0000_7000, PR, 32'h8888_8080);
    expect_look("R7 probe fill", 32'h0000_7000, RD, MISS, 0);
  endtask

  task automatic t_inval;
    fill(32'h0000_8000, RD, 32'h9999_9080);
    fill(32'h0001_8000, WR, 32'h9999_A080);
    fill(32'h0000_8000, FE, 32'h9999_B080);
    inval(32'h0002_8ABC);
    expect_look("R8 data w0", 32'h0000_8000, RD, MISS, 0);
    expect_look("R8 data w1", 32'h0001_8000, RD, MISS, 0);
    expect_look("R8 instr", 32'h0000_8000, FE, MISS, 0);
    expect_look("R8 other set", 32'h0000_3000, RD, HIT, 32'h1234_5000);
  endtask

  task automatic t_collide;
    fill(32'h0000_9000, RD, 32'hC1C1_C080);
    fill(32'h0001_9000, RD, 32'hC2C2_C080);
    @(negedge clk);
    lk_addr = 32'h0001_9044; lk_kind = RD; lk_valid = 1;
    fl_addr = 32'h0002_9000; fl_kind = RD; fl_pte = 32'hC3C3_C080; fl_valid = 1;
    @(posedge clk); @(negedge clk); lk_valid = 0; fl_valid = 0;
    chk("R9 old contents status", rs_status, HIT);
    chk("R9 old contents paddr", rs_paddr, 32'hC2C2_C044);
    fill(32'h0003_9000, RD, 32'hC4C4_C080);
    expect_look("R9 fill recency kept", 32'h0001_9000, RD, MISS, 0);
    expect_look("R9 fill way0", 32'h0002_9000, RD, HIT, 32'hC3C3_C000);
  endtask

  task automatic t_backpressure;
    @(negedge clk); rs_ready = 0; lk_addr = 32'h0000_3456; lk_kind = RD; lk_valid = 1;
    @(posedge clk); @(negedge clk);
    lk_addr = 32'h0000_7000;
    chk("R10 ready low", lk_ready, 0);
    repeat (2) @(negedge clk);
    chk("R10 held valid", rs_valid, 1);
    chk("R10 held status", rs_status, HIT);
    chk("R10 held paddr", rs_paddr, 32'h1234_5456);
    rs_ready = 1;
    @(posedge clk); @(negedge clk); lk_valid = 0;
    chk("R10 next status", rs_status, MISS);
    @(posedge clk); @(negedge clk);
    chk("R10 drained", rs_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_replace;
    t_probe;
    t_inval;
    t_collide;
    t_backpressure;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule